// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single read and write transactions on the two-wire management bus that sits between a MAC and an Ethernet PHY. The host first sets up a 16-bit data register, then writes a command word. The command word selects read or write and names the PHY and the register inside that PHY. The controller derives the management clock from the system clock with a programmable divisor. It shifts out the whole frame. On a read, it releases the data line for the turnaround and collects the sixteen bits that the PHY returns. While the frame is in progress a busy flag stays high, and the host polls it.

All host-side pins are plain strobes and levels; there is no back-pressure. A command or data write that arrives while busy is high is dropped, so the host must wait for busy to fall before it issues the next operation. A preamble-skip level is sampled when each command is accepted. When it is high, the frame starts directly at the start-of-frame pattern and leaves out the 32 leading ones. The divisor register can be rewritten at any time. Its value is captured when a command is accepted, so a running frame keeps the clock rate it started with.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, busy, mdc and mdio_oe are low, data_out is zero and the divisor register holds 32.
- R2: Command bit 11 requests a read and bit 10 requests a write. Bits 9:5 carry the PHY address and bits 4:0 the register address. A command with both op bits set or neither set is dropped and starts nothing.
- R3: While busy, mdc has a period of D system clocks. It is low for the first floor(D/2) clocks of each bit and high for the rest. While idle, mdc is held low.
- R4: D is the divisor register value captured at command acceptance. A value of 0 or 1 is used as 2, and the value after reset is 32.
- R5: A full frame lasts 64 bit periods. In order, it carries 32 ones, start 0 then 1, op (read 1,0; write 0,1), five PHY address bits and five register address bits (each MSB first), turnaround 1,0, and 16 data bits MSB first. Each bit changes at the start of its period.
- R6: When pre_sup is high at acceptance, the 32 ones are omitted and the frame lasts 32 bit periods.
- R7: On a read, mdio_oe goes low from the first turnaround bit to the end of the frame. mdio_i is sampled at each mdc rising edge of the 16 data bits. data_out shows the captured value from the cycle busy falls.
- R8: On a write, the data register value held at acceptance is sent as the data field. data_out keeps that value.
- R9: busy rises on the clock edge that accepts a command and falls when the last bit period ends. A command or a data write arriving while busy is high has no effect.
- R10: Rewriting the divisor during a frame does not change that frame's timing; the next frame uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divisor register write strobe |
| div_val | input | DIV_W | New divisor value |
| pre_sup | input | 1 | Skip preamble for commands accepted while high |
| data_we | input | 1 | Data register write strobe (ignored while busy) |
| data_in | input | 16 | Write data for the data register |
| cmd_we | input | 1 | Command write strobe; starts a frame when idle |
| cmd_in | input | 12 | Command word: op bits 11/10, PHY 9:5, register 4:0 |
| busy | output | 1 | High while a frame is in progress |
| data_out | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pad |

## Verification
The bench targets the divisor corners. A value of 0 or 1 that was not clamped would stall or race the clock. An odd divisor would expose a wrong split between the low and high phases. A divisor rewritten mid-frame would stretch a frame that latched it wrongly. Reads are checked against a responder that decodes the header and answers in the turnaround slot. If the line is released one bit too late there is contention, and if sampling happens on the wrong edge the data is shifted by one bit. The bench also fires a command and a data write into a busy frame, and sends commands with both or neither op bit set. A design that queued them would start an extra frame or corrupt the data register.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_W = 64;
  localparam int PRE_W   = 32;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int CMD_W   = 12;

  // command word layout
  localparam int CMD_RD_BIT = 11;
  localparam int CMD_WR_BIT = 10;
  localparam int PHY_LSB    = 5;
  localparam int REG_LSB    = 0;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  // Assemble the complete frame, first bit on the wire in the MSB.
  function automatic logic [FRAME_W-1:0] build_frame(
    input mdio_op_e            op,
    input logic [ADDR_W-1:0]   phy,
    input logic [ADDR_W-1:0]   ra,
    input logic [DATA_W-1:0]   wd
  );
    logic [DATA_W-1:0] payload;
    payload = (op == OP_RD) ? '1 : wd;
    return {{PRE_W{1'b1}}, 2'b01, op, phy, ra, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             bit_end
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_inc;
  logic [DIV_W-1:0] half;

  assign half     = div >> 1;
  assign cnt_inc  = cnt + 1'b1;
  assign bit_end  = run && (cnt == div - 1'b1);
  // the edge that makes mdc rise
  assign rise_evt = run && (cnt_inc == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run || bit_end) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_inc;
      mdc <= (cnt_inc >= half);
    end
  end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               skip_pre,
  input  logic               is_read_in,
  input  logic               rise_evt,
  input  logic               bit_end,
  input  logic               mdio_i,
  output logic               active,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rd_done,
  output logic [DATA_W-1:0]  capt
);

  localparam int PTR_W    = $clog2(FRAME_W);
  localparam int TA_POS   = FRAME_W - DATA_W - 2;
  localparam int DATA_POS = FRAME_W - DATA_W;
  localparam int LAST     = FRAME_W - 1;

  logic [FRAME_W-1:0] sr;
  logic [PTR_W-1:0]   ptr;
  logic               rd_q;
  logic               last_bit;

  assign last_bit = active && bit_end && (ptr == PTR_W'(LAST));
  assign rd_done  = last_bit && rd_q;
  assign mdio_o   = sr[FRAME_W-1];
  assign mdio_oe  = active && !(rd_q && (ptr >= PTR_W'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      ptr    <= '0;
      rd_q   <= 1'b0;
      active <= 1'b0;
      capt   <= '0;
    end else if (load) begin
      sr     <= skip_pre ? (frame_in << PRE_W) : frame_in;
      ptr    <= skip_pre ? PTR_W'(PRE_W) : '0;
      rd_q   <= is_read_in;
      active <= 1'b1;
    end else if (active) begin
      if (rise_evt && rd_q && (ptr >= PTR_W'(DATA_POS)))
        capt <= {capt[DATA_W-2:0], mdio_i};
      if (bit_end) begin
        sr <= sr << 1;
        if (last_bit) active <= 1'b0;
        else          ptr    <= ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              pre_sup,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_in,
  output logic              busy,
  output logic [DATA_W-1:0] data_out,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic               active, accept, cmd_ok, is_rd;
  logic               rise_evt, bit_end, rd_done;
  logic [DIV_W-1:0]   div_reg, div_run, div_eff;
  logic [DATA_W-1:0]  data_reg, capt;
  logic [FRAME_W-1:0] frame;

  assign is_rd   = cmd_in[CMD_RD_BIT];
  assign cmd_ok  = cmd_in[CMD_RD_BIT] ^ cmd_in[CMD_WR_BIT];
  assign accept  = cmd_we && cmd_ok && !active;
  assign div_eff = (div_reg < DIV_MIN) ? DIV_MIN : div_reg;
  assign frame   = build_frame(is_rd ? OP_RD : OP_WR,
                               cmd_in[PHY_LSB +: ADDR_W],
                               cmd_in[REG_LSB +: ADDR_W],
                               data_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_reg <= DIV_W'(DIV_RESET);
      div_run <= DIV_MIN;
    end else begin
      if (div_we) div_reg <= div_val;
      if (accept) div_run <= div_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                data_reg <= '0;
    else if (rd_done)          data_reg <= capt;
    else if (data_we && !active) data_reg <= data_in;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active),
    .div      (div_run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .bit_end  (bit_end)
  );

  mdio_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .frame_in   (frame),
    .skip_pre   (pre_sup),
    .is_read_in (is_rd),
    .rise_evt   (rise_evt),
    .bit_end    (bit_end),
    .mdio_i     (mdio_i),
    .active     (active),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_done    (rd_done),
    .capt       (capt)
  );

  assign busy     = active;
  assign data_out = data_reg;

endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        cmd_we,
  input logic [15:0] data_out
);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_mdc_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  p_start_from_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we));

  p_data_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(data_out) || !busy));

  p_no_reclaim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |=> !mdio_oe);

endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_oe  (mdio_oe),
  .cmd_we   (cmd_we),
  .data_out (data_out)
);

// File: tb/mdio_ctrl_test.sv
module mdio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_we = 1'b0;
  logic [7:0]  div_val = '0;
  logic        pre_sup = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] data_in = '0;
  logic        cmd_we = 1'b0;
  logic [11:0] cmd_in = '0;
  logic        phy_oe = 1'b0;
  logic        phy_bit = 1'b1;
  wire         busy, mdc, mdio_o, mdio_oe;
  wire  [15:0] data_out;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

  always #4 clk = ~clk;

  mdio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_val(div_val),
    .pre_sup(pre_sup), .data_we(data_we), .data_in(data_in),
    .cmd_we(cmd_we), .cmd_in(cmd_in), .busy(busy), .data_out(data_out),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'b101101};
  endfunction

  // ---------------- reference model ----------------
  bit m_busy, m_mdc, m_rd;
  int m_cnt, m_D, m_H, m_ptr, m_div, m_data, m_sr;
  bit mf [64];
  bit ln = 1'b1;
  bit cmp_on = 1'b0;
  bit exp_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_mdc = 0; m_rd = 0; m_cnt = 0; m_D = 2; m_H = 1;
      m_ptr = 0; m_div = 32; m_data = 0; m_sr = 0;
    end else if (m_busy) begin
      if (m_cnt + 1 == m_H && m_rd && m_ptr >= 48) m_sr = ((m_sr << 1) | int'(ln)) & 16'hFFFF;
      if (m_cnt == m_D - 1) begin
        m_cnt = 0; m_mdc = 0;
        if (m_ptr == 63) begin
          m_busy = 0;
          if (m_rd) m_data = m_sr;
        end else m_ptr++;
      end else begin
        m_cnt++;
        m_mdc = (m_cnt >= m_H);
      end
      if (div_we) m_div = int'(div_val);
    end else begin
      if (cmd_we && (cmd_in[11] != cmd_in[10])) begin
        m_D = (m_div < 2) ? 2 : m_div;
        m_H = m_D / 2;
        m_rd = cmd_in[11];
        m_ptr = pre_sup ? 32 : 0;
        m_cnt = 0; m_mdc = 0; m_busy = 1;
        for (int i = 0; i < 32; i++) mf[i] = 1'b1;
        mf[32] = 0; mf[33] = 1; mf[34] = m_rd; mf[35] = !m_rd;
        for (int i = 0; i < 5; i++) begin
          mf[36+i] = cmd_in[9-i];
          mf[41+i] = cmd_in[4-i];
        end
        mf[46] = 1; mf[47] = 0;
        for (int i = 0; i < 16; i++) mf[48+i] = m_data[15-i];
      end
      if (div_we)  m_div = int'(div_val);
      if (data_we) m_data = int'(data_in);
    end
  end

  // ---------------- comparison and PHY responder ----------------
  bit          mdc_prev, seen_zero, talk;
  int          hcnt, tcnt, wcnt;
  logic [13:0] hdr;
  logic [17:0] wcap;
  logic [15:0] rv;
  logic [15:0] last_wr = '0;

  always @(negedge clk) begin
    if (cmp_on) begin
      exp_oe = m_busy && !(m_rd && m_ptr >= 46);
      check(busy === m_busy, "R9 busy", int'(busy), int'(m_busy));
      check(mdc === m_mdc, "R3 mdc", int'(mdc), int'(m_mdc));
      check(mdio_oe === exp_oe, "R7 mdio_oe", int'(mdio_oe), int'(exp_oe));
      check(data_out === 16'(m_data), "R8 data_out", int'(data_out), m_data);
      if (exp_oe) check(mdio_o === mf[m_ptr], "R5 mdio_o", int'(mdio_o), int'(mf[m_ptr]));
      check(!(mdio_oe === 1'b1 && phy_oe), "R7 contention", int'(phy_oe), 0);
    end
    if (busy !== 1'b1) begin
      seen_zero = 0; talk = 0; phy_oe = 0; hcnt = 0; tcnt = 0; wcnt = 18;
    end else begin
      if (mdc === 1'b1 && !mdc_prev) begin
        if (!seen_zero) begin
          if (mdio_line === 1'b0) begin seen_zero = 1; hdr = '0; hcnt = 1; end
        end else if (hcnt < 14) begin
          hdr = {hdr[12:0], mdio_line};
          hcnt++;
          if (hcnt == 14) begin
            if (hdr[11:10] == 2'b10) begin
              talk = 1; tcnt = 0; rv = resp(hdr[9:5], hdr[4:0]);
            end else wcnt = 0;
          end
        end else if (wcnt < 18) begin
          wcap = {wcap[16:0], mdio_line};
          wcnt++;
          if (wcnt == 18) last_wr = wcap[15:0];
        end
      end
      if (mdc === 1'b0 && mdc_prev && talk) begin
        tcnt++;
        if (tcnt == 1) phy_oe = 0;
        else if (tcnt == 2) begin phy_oe = 1; phy_bit = 0; end
        else if (tcnt <= 18) phy_bit = rv[18-tcnt];
        else begin phy_oe = 0; talk = 0; end
      end
    end
    mdc_prev = (mdc === 1'b1);
    ln = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);
  end

  // ---------------- stimulus ----------------
  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic set_div(input logic [7:0] v);
    div_val = v; div_we = 1; tick; div_we = 0;
  endtask

  task automatic set_data(input logic [15:0] v);
    data_in = v; data_we = 1; tick; data_we = 0;
  endtask

  task automatic run_cmd(input logic rd, input logic [4:0] p, input logic [4:0] r, output int n);
    cmd_in = {rd, !rd, p, r}; cmd_we = 1; tick; cmd_we = 0;
    n = 0;
    while (busy === 1'b1) begin tick; n++; end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary;
    $finish;
  end

  initial begin
    int n;
    logic [15:0] saved;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cmp_on = 1;
    tick;
    // R1 reset state
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(mdc === 1'b0, "R1 mdc after reset", int'(mdc), 0);
    check(mdio_oe === 1'b0, "R1 mdio_oe after reset", int'(mdio_oe), 0);
    check(data_out === 16'h0, "R1 data_out after reset", int'(data_out), 0);

    // R4 default divisor, R5 full write frame, R8 data sent
    set_data(16'hA5C3);
    run_cmd(1'b0, 5'd3, 5'd17, n);
    check(n == 64 * 32, "R4 default divisor frame length", n, 64 * 32);
    check(last_wr === 16'hA5C3, "R8 written data on the wire", int'(last_wr), 16'hA5C3);
    check(data_out === 16'hA5C3, "R8 data_out after write", int'(data_out), 16'hA5C3);

    // R5 / R7 full read frame
    set_div(8'd4);
    run_cmd(1'b1, 5'd5, 5'd9, n);
    check(n == 256, "R5 full frame length", n, 256);
    check(data_out === resp(5'd5, 5'd9), "R7 read data", int'(data_out), int'(resp(5'd5, 5'd9)));

    // R6 preamble skipped
    pre_sup = 1;
    run_cmd(1'b1, 5'd31, 5'd0, n);
    check(n == 128, "R6 short frame length", n, 128);
    check(data_out === resp(5'd31, 5'd0), "R7 read data short frame", int'(data_out), int'(resp(5'd31, 5'd0)));
    pre_sup = 0;

    // R4 clamp of 0 and 1
    set_div(8'd0);
    set_data(16'h0F0F);
    run_cmd(1'b0, 5'd1, 5'd2, n);
    check(n == 128, "R4 divisor 0 used as 2", n, 128);
    check(last_wr === 16'h0F0F, "R8 write data at fastest clock", int'(last_wr), 16'h0F0F);
    set_div(8'd1);
    pre_sup = 1;
    run_cmd(1'b1, 5'd7, 5'd30, n);
    check(n == 64, "R4 divisor 1 used as 2", n, 64);
    check(data_out === resp(5'd7, 5'd30), "R7 read at fastest clock", int'(data_out), int'(resp(5'd7, 5'd30)));
    pre_sup = 0;

    // R3 odd divisor
    set_div(8'd5);
    run_cmd(1'b1, 5'd18, 5'd5, n);
    check(n == 320, "R3 odd divisor frame length", n, 320);
    check(data_out === resp(5'd18, 5'd5), "R7 read with odd divisor", int'(data_out), int'(resp(5'd18, 5'd5)));

    // R2 malformed commands
    saved = data_out;
    cmd_in = 12'hC25; cmd_we = 1; tick; cmd_we = 0;
    repeat (4) tick;
    check(busy === 1'b0, "R2 both op bits dropped", int'(busy), 0);
    cmd_in = 12'h025; cmd_we = 1; tick; cmd_we = 0;
    repeat (4) tick;
    check(busy === 1'b0, "R2 no op bit dropped", int'(busy), 0);
    check(data_out === saved, "R2 data unchanged", int'(data_out), int'(saved));

    // R9 writes during busy are dropped
    set_div(8'd4);
    set_data(16'h1234);
    cmd_in = {1'b0, 1'b1, 5'd2, 5'd3}; cmd_we = 1; tick; cmd_we = 0;
    n = 0;
    repeat (10) begin tick; n++; end
    cmd_in = {1'b1, 1'b0, 5'd4, 5'd4}; cmd_we = 1;
    data_in = 16'hDEAD; data_we = 1;
    tick; n++;
    cmd_we = 0; data_we = 0;
    while (busy === 1'b1) begin tick; n++; end
    check(n == 256, "R9 frame length with stray command", n, 256);
    repeat (5) tick;
    check(busy === 1'b0, "R9 stray command not queued", int'(busy), 0);
    check(data_out === 16'h1234, "R9 data write during busy dropped", int'(data_out), 16'h1234);
    check(last_wr === 16'h1234, "R9 frame data intact", int'(last_wr), 16'h1234);

    // R10 divisor rewrite mid-frame
    cmd_in = {1'b1, 1'b0, 5'd9, 5'd12}; cmd_we = 1; tick; cmd_we = 0;
    n = 0;
    repeat (20) begin tick; n++; end
    div_val = 8'd2; div_we = 1; tick; n++; div_we = 0;
    while (busy === 1'b1) begin tick; n++; end
    check(n == 256, "R10 running frame keeps divisor", n, 256);
    check(data_out === resp(5'd9, 5'd12), "R10 read data", int'(data_out), int'(resp(5'd9, 5'd12)));
    run_cmd(1'b0, 5'd0, 5'd1, n);
    check(n == 128, "R10 next frame uses new divisor", n, 128);

    repeat (4) tick;
    summary;
    $finish;
  end

endmodule